// File: doc/BRIEF.md
# Register Command Queue Engine

This block runs a list of 32-bit commands against a bank of 8-bit registers. Software first places the list in a single-port command buffer. It then writes one control word that carries a start flag and the list length in bytes. The engine fetches each entry in turn and decodes it as one of three kinds:

- a masked register write;
- a register read, whose result is written back into the entry;
- a poll that waits until masked register bits equal an expected value.

When the list finishes, the engine raises a one-cycle success or failure interrupt. A stop flag in the same control word abandons a running list.

Register accesses go out on a request/acknowledge bus whose latency is set by the responder. The request acts as "valid" and the acknowledge as "ready". Once a request is raised, its write flag, address and write data stay fixed until the cycle in which the acknowledge is seen. The responder applies back-pressure simply by holding the acknowledge low. An acknowledge in the same cycle as the request is legal.

The command buffer returns read data one cycle after a read enable and accepts writes in the cycle they are presented. It never stalls.

Top module: `regq_engine`

## Requirements
- R1: A command entry is decoded as follows:
  - bits [31:30] select the kind: 0 = read, 1 = masked write, 2 = check, 3 = reserved;
  - bits [29:16] are the register address;
  - bits [15:8] are the mask;
  - bits [7:0] are the data.
- R2: A control write with bit 31 set, issued while idle, runs entries 0, 1, 2 … in order. Bits [23:0] of that write give the list length in bytes; it holds (bytes/4) entries. Bit 30 of the control word is the stop flag.
- R3: A masked write leaves the register at (old & ~mask) | (data & mask). It reads the old value first, except when mask = 0xFF, where it issues a single bus write of the data and no read.
- R4: A read command stores the returned byte in bits [7:0] of its own buffer entry and leaves bits [31:8] of that entry unchanged.
- R5: A check re-reads its register until (value ^ data) & mask == 0, then advances. Once the number of mismatching reads exceeds poll_limit, the list ends with a failure and no later entry is run.
- R6: After the last entry completes, irq_ok pulses for exactly one cycle, in the first cycle in which busy is low. irq_ok and irq_fail are never high together.
- R7: A start whose byte count is zero, is not a multiple of 4, or exceeds 4×DEPTH (1024 by default) pulses irq_fail in the cycle after the control write. It makes no buffer or bus access. A count of exactly 4×DEPTH is accepted.
- R8: A start issued while busy is ignored; the running list continues unchanged.
- R9: A stop issued while busy ends the list with no interrupt. An outstanding bus access completes first, and later entries are not run. While idle, neither reg_req nor buf_en is asserted.
- R10: A reserved-kind entry ends the list with irq_fail, and no later entry is run.
- R11: While reg_req is high and reg_ack is low, reg_req, reg_we, reg_addr and reg_wdata hold their values into the next cycle.
- R12: After reset, busy, irq_ok, irq_fail, reg_req and buf_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word: bit 31 start, bit 30 stop, [23:0] byte count |
| poll_limit | input | POLL_W | Mismatching check reads tolerated before failure |
| buf_en | output | 1 | Command buffer access enable |
| buf_we | output | 1 | Command buffer write (write-back of a read result) |
| buf_addr | output | IDX_W | Command buffer entry index |
| buf_wdata | output | 32 | Command buffer write data |
| buf_rdata | input | 32 | Command buffer read data, one cycle after a read enable |
| reg_req | output | 1 | Register bus request (valid) |
| reg_we | output | 1 | Register bus write flag |
| reg_addr | output | 14 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, sampled with reg_ack |
| reg_ack | input | 1 | Register bus acknowledge (ready) |
| busy | output | 1 | A list is running |
| irq_ok | output | 1 | One-cycle pulse: list completed |
| irq_fail | output | 1 | One-cycle pulse: list failed or start rejected |

## Verification
A stale entry index or a corrupted latched command word shows up on the register bus at the very next acknowledged access, as a wrong address, kind or write value. The bench therefore compares every acknowledged access, in the cycle it happens, against a queue of accesses predicted from the requirements.

A wrong poll counter or stop latch only shows up at the end of the list. It appears as the wrong interrupt, a missing interrupt, or registers past the failing entry being changed. These are caught by comparing the final register bank and buffer contents against the model.

Rejected starts are caught within one cycle, by checking the interrupt pulse and confirming that no access appears.

// File: rtl/regq_pkg.sv
package regq_pkg;
  localparam int REG_AW = 14;
  localparam int REG_DW = 8;
  localparam int CMD_W  = 32;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_CHECK = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [REG_AW-1:0]  addr;
    logic [REG_DW-1:0]  mask;
    logic [REG_DW-1:0]  data;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LATCH, S_RD, S_WR, S_WB
  } state_e;
endpackage

// File: rtl/regq_ctl_decode.sv
module regq_ctl_decode #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 24
) (
  input  logic                       ctl_wr,
  input  logic [31:0]                ctl_wdata,
  input  logic                       busy,
  output logic                       go,
  output logic                       bad,
  output logic                       stop,
  output logic [$clog2(DEPTH)-1:0]   last_idx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] MAX_BYTES = CNT_W'(4 * DEPTH);

  logic [CNT_W-1:0] bytes;
  logic [CNT_W-1:0] words_m1;
  logic             start_req;
  logic             len_ok;
  logic             unused_ctl;

  assign bytes      = ctl_wdata[CNT_W-1:0];
  assign start_req  = ctl_wr && ctl_wdata[31] && !busy;
  assign len_ok     = (bytes != '0) && (bytes[1:0] == 2'b00) && (bytes <= MAX_BYTES);
  assign go         = start_req && len_ok;
  assign bad        = start_req && !len_ok;
  assign stop       = ctl_wr && ctl_wdata[30] && busy;
  assign words_m1   = (bytes >> 2) - CNT_W'(1);
  assign last_idx   = words_m1[IDX_W-1:0];
  assign unused_ctl = ^{ctl_wdata[29:CNT_W], words_m1[CNT_W-1:IDX_W]};
endmodule

// File: rtl/regq_merge.sv
module regq_merge
  import regq_pkg::*;
(
  input  cmd_t              cmd,
  input  logic [REG_DW-1:0] rd,
  output logic [REG_DW-1:0] merged,
  output logic              match
);
  assign merged = (rd & ~cmd.mask) | (cmd.data & cmd.mask);
  assign match  = ((rd ^ cmd.data) & cmd.mask) == '0;
endmodule

// File: rtl/regq_fsm.sv
module regq_fsm
  import regq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int POLL_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              bad,
  input  logic              stop,
  input  logic [IDX_W-1:0]  last_in,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              buf_en,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_addr,
  output logic [CMD_W-1:0]  buf_wdata,
  input  logic [CMD_W-1:0]  buf_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] reg_wdata,
  input  logic [REG_DW-1:0] reg_rdata,
  input  logic              reg_ack,
  input  logic [REG_DW-1:0] merged,
  input  logic              match,
  output cmd_t              cmd_o,
  output logic              busy,
  output logic              irq_ok,
  output logic              irq_fail
);
  state_e            state_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  cmd_t              cmd_q;
  logic [REG_DW-1:0] wval_q, rd_q;
  logic [POLL_W-1:0] polls_q;
  logic              stop_pend_q;
  logic              stop_now;
  logic              at_last;
  cmd_t              fetched;

  assign fetched  = cmd_t'(buf_rdata);
  assign stop_now = stop_pend_q || stop;
  assign at_last  = (idx_q == last_q);
  assign cmd_o    = cmd_q;
  assign busy     = (state_q != S_IDLE);

  assign buf_en    = (state_q == S_FETCH) || (state_q == S_WB);
  assign buf_we    = (state_q == S_WB);
  assign buf_addr  = idx_q;
  assign buf_wdata = {cmd_q[CMD_W-1:REG_DW], rd_q};
  assign reg_req   = (state_q == S_RD) || (state_q == S_WR);
  assign reg_we    = (state_q == S_WR);
  assign reg_addr  = cmd_q.addr;
  assign reg_wdata = wval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      cmd_q       <= '0;
      wval_q      <= '0;
      rd_q        <= '0;
      polls_q     <= '0;
      stop_pend_q <= 1'b0;
      irq_ok      <= 1'b0;
      irq_fail    <= 1'b0;
    end else begin
      irq_ok      <= 1'b0;
      irq_fail    <= 1'b0;
      stop_pend_q <= busy && stop_now;
      unique case (state_q)
        S_IDLE: begin
          if (go) begin
            idx_q   <= '0;
            last_q  <= last_in;
            state_q <= S_FETCH;
          end
          if (bad) irq_fail <= 1'b1;
        end
        S_FETCH: state_q <= stop_now ? S_IDLE : S_LATCH;
        S_LATCH: begin
          if (stop_now) state_q <= S_IDLE;
          else begin
            cmd_q   <= fetched;
            polls_q <= '0;
            unique case (fetched.kind)
              K_READ, K_CHECK: state_q <= S_RD;
              K_WRITE: begin
                if (fetched.mask == '1) begin
                  wval_q  <= fetched.data;
                  state_q <= S_WR;
                end else state_q <= S_RD;
              end
              default: begin
                state_q  <= S_IDLE;
                irq_fail <= 1'b1;
              end
            endcase
          end
        end
        S_RD: begin
          if (reg_ack) begin
            if (stop_now) state_q <= S_IDLE;
            else begin
              unique case (cmd_q.kind)
                K_READ: begin
                  rd_q    <= reg_rdata;
                  state_q <= S_WB;
                end
                K_WRITE: begin
                  wval_q  <= merged;
                  state_q <= S_WR;
                end
                default: begin
                  if (match) begin
                    if (at_last) begin state_q <= S_IDLE; irq_ok <= 1'b1; end
                    else begin idx_q <= idx_q + 1'b1; state_q <= S_FETCH; end
                  end else if (polls_q == poll_limit) begin
                    state_q  <= S_IDLE;
                    irq_fail <= 1'b1;
                  end else polls_q <= polls_q + 1'b1;
                end
              endcase
            end
          end
        end
        S_WR, S_WB: begin
          if (state_q == S_WB || reg_ack) begin
            if (stop_now) state_q <= S_IDLE;
            else if (at_last) begin state_q <= S_IDLE; irq_ok <= 1'b1; end
            else begin idx_q <= idx_q + 1'b1; state_q <= S_FETCH; end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regq_engine.sv
module regq_engine
  import regq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int POLL_W = 16,
  parameter int CNT_W  = 24,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              buf_en,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_addr,
  output logic [31:0]       buf_wdata,
  input  logic [31:0]       buf_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [13:0]       reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_ack,
  output logic              busy,
  output logic              irq_ok,
  output logic              irq_fail
);
  logic             go, bad, stop;
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       merged;
  logic             match;
  cmd_t             cmd_cur;

  regq_ctl_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dec (
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .busy(busy),
    .go(go), .bad(bad), .stop(stop), .last_idx(last_idx)
  );

  regq_merge u_merge (
    .cmd(cmd_cur), .rd(reg_rdata), .merged(merged), .match(match)
  );

  regq_fsm #(.DEPTH(DEPTH), .POLL_W(POLL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .bad(bad), .stop(stop),
    .last_in(last_idx), .poll_limit(poll_limit),
    .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .merged(merged), .match(match), .cmd_o(cmd_cur),
    .busy(busy), .irq_ok(irq_ok), .irq_fail(irq_fail)
  );
endmodule

// File: rtl/regq_engine_chk.sv
module regq_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq_ok,
  input logic        irq_fail,
  input logic        reg_req,
  input logic        reg_ack,
  input logic        reg_we,
  input logic [13:0] reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        buf_en
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)); // R11
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ok && irq_fail)); // R6
  AST_OK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ok |-> !busy && $past(busy)); // R6
  AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ok |=> !irq_ok); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req && !buf_en); // R9
endmodule

bind regq_engine regq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq_ok(irq_ok), .irq_fail(irq_fail),
  .reg_req(reg_req), .reg_ack(reg_ack), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .buf_en(buf_en)
);

// File: tb/regq_engine_bench.sv
module regq_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [15:0] poll_limit = '0;
  logic        buf_en, buf_we;
  logic [7:0]  buf_addr;
  logic [31:0] buf_wdata;
  logic [31:0] buf_rdata = '0;
  logic        reg_req, reg_we, reg_ack;
  logic [13:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        busy, irq_ok, irq_fail;

  always #10 clk = ~clk;

  regq_engine u_regq_engine (.*);

  logic [31:0] mem  [0:255];
  logic [7:0]  regs [0:63];
  logic [7:0]  pctr = '0;
  logic [31:0] mmem [0:255];
  logic [7:0]  mreg [0:63];
  logic [7:0]  mpc;
  logic [22:0] expq [$];
  logic [22:0] act_tx, e_tx;
  int lat = 0, wcnt = 0, ntx = 0, nbuf = 0;
  int nchk = 0, nbad = 0;
  bit cmpq_en = 0, fin = 0;

  assign reg_ack   = reg_req && (wcnt == lat);
  assign reg_rdata = (reg_addr[5:0] == 6'd63) ? pctr : regs[reg_addr[5:0]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Buffer memory and register responder; every acknowledged access is compared to the model queue.
  always @(posedge clk) begin
    if (buf_en) begin
      nbuf++;
      if (buf_we) mem[buf_addr] <= buf_wdata;
      else buf_rdata <= mem[buf_addr];
    end
    if (reg_req && !reg_ack) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (reg_req && reg_ack) begin
      ntx++;
      act_tx = {reg_we, reg_addr, reg_we ? reg_wdata : 8'h00};
      if (cmpq_en) begin
        if (expq.size() == 0) chk(0, "R2 unexpected bus access", {9'b0, act_tx}, 0);
        else begin
          e_tx = expq.pop_front();
          chk(e_tx[22] ? (e_tx == act_tx) : (e_tx[22:8] == act_tx[22:8]),
              "R3/R1 bus access", {9'b0, act_tx}, {9'b0, e_tx});
        end
      end
      if (reg_we) regs[reg_addr[5:0]] <= reg_wdata;
      else if (reg_addr[5:0] == 6'd63) pctr <= pctr + 8'd1;
    end
  end

  function automatic logic [31:0] mk(input logic [1:0] k, input logic [13:0] a,
                                     input logic [7:0] m, input logic [7:0] d);
    return {k, a, m, d};
  endfunction

  task automatic mrd(input logic [13:0] a, output logic [7:0] v);
    expq.push_back({1'b0, a, 8'h00});
    if (a[5:0] == 6'd63) begin v = mpc; mpc = mpc + 8'd1; end
    else v = mreg[a[5:0]];
  endtask

  task automatic model(input int nw, input int lim, output bit ok);
    logic [31:0] w; logic [7:0] v, m, d; logic [13:0] a; int mis;
    ok = 1;
    for (int i = 0; i < nw; i++) begin
      w = mmem[i]; a = w[29:16]; m = w[15:8]; d = w[7:0];
      case (w[31:30])
        2'd0: begin mrd(a, v); mmem[i][7:0] = v; end
        2'd1: begin
          if (m != 8'hFF) begin mrd(a, v); v = (v & ~m) | (d & m); end
          else v = d;
          expq.push_back({1'b1, a, v});
          mreg[a[5:0]] = v;
        end
        2'd2: begin
          mis = 0;
          forever begin
            mrd(a, v);
            if (((v ^ d) & m) == 8'h00) break;
            mis++;
            if (mis > lim) begin ok = 0; return; end
          end
        end
        default: begin ok = 0; return; end
      endcase
    end
  endtask

  task automatic start(input int bytes, input int lim, input bit stp);
    ctl_wdata = {1'b1, stp, 6'd0, 24'(bytes)};
    poll_limit = 16'(lim);
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic run_case(input int nw, input int lim, input int l, input string tag);
    bit eok; int t, bad_r, bad_m;
    lat = l; pctr = 8'd0;
    for (int i = 0; i < 256; i++) mmem[i] = mem[i];
    for (int i = 0; i < 64; i++) mreg[i] = regs[i];
    mpc = 8'd0;
    expq.delete();
    model(nw, lim, eok);
    cmpq_en = 1;
    start(nw * 4, lim, 1'b0);
    t = 0;
    while (!(irq_ok || irq_fail) && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, {tag, " R2 list completes"}, t, 20000);
    chk(irq_ok == eok && irq_fail == !eok, {tag, " R6/R5/R10 interrupt kind"},
        {irq_ok, irq_fail}, {eok, !eok});
    chk(busy == 1'b0, {tag, " R6 busy low with interrupt"}, busy, 0);
    chk(expq.size() == 0, {tag, " R2 all predicted accesses seen"}, expq.size(), 0);
    bad_r = 0; bad_m = 0;
    for (int i = 0; i < 63; i++) if (regs[i] !== mreg[i]) bad_r++;
    for (int i = 0; i < 256; i++) if (mem[i] !== mmem[i]) bad_m++;
    chk(bad_r == 0, {tag, " R3 register bank"}, bad_r, 0);
    chk(bad_m == 0, {tag, " R4 buffer write-back"}, bad_m, 0);
    cmpq_en = 0;
    @(negedge clk);
    chk(!irq_ok && !irq_fail, {tag, " R6 one-cycle pulse"}, {irq_ok, irq_fail}, 0);
  endtask

  task automatic bad_start(input int bytes, input string tag);
    int t0, b0;
    t0 = ntx; b0 = nbuf;
    start(bytes, 0, 1'b0);
    chk(irq_fail && !irq_ok && !busy, {tag, " R7 immediate fail"}, {busy, irq_ok, irq_fail}, 1);
    repeat (4) @(negedge clk);
    chk(ntx == t0 && nbuf == b0 && !irq_fail, {tag, " R7 no access"}, ntx - t0 + nbuf - b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nchk++; nbad++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int t;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) regs[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    chk(!busy && !irq_ok && !irq_fail && !reg_req && !buf_en, "R12 reset state",
        {busy, irq_ok, irq_fail, reg_req, buf_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4 masked writes and reads, zero-latency bus
    mem[0] = mk(2'd1, 14'd5, 8'hFF, 8'hA5);
    mem[1] = mk(2'd1, 14'd5, 8'h0F, 8'h3C);
    mem[2] = mk(2'd0, 14'd5, 8'h12, 8'h34);
    mem[3] = mk(2'd0, 14'd7, 8'hAB, 8'h00);
    run_case(4, 0, 0, "A");
    chk(regs[5] == 8'hAC, "R3 masked merge value", regs[5], 8'hAC);
    chk(mem[2] == 32'h0005_12AC, "R4 entry keeps upper bits", mem[2], 32'h0005_12AC);

    // R11 same pattern under a slow responder, plus an immediate check match (R5)
    mem[0] = mk(2'd1, 14'd9, 8'hF0, 8'h5A);
    mem[1] = mk(2'd2, 14'd9, 8'hF0, 8'h50);
    mem[2] = mk(2'd0, 14'd9, 8'h00, 8'h00);
    mem[3] = mk(2'd1, 14'd62, 8'hFF, 8'h6E);
    run_case(4, 0, 3, "B");

    // R5 check passes after polling
    mem[0] = mk(2'd2, 14'd63, 8'hFF, 8'h03);
    mem[1] = mk(2'd1, 14'd11, 8'hFF, 8'h99);
    run_case(2, 5, 1, "C");
    chk(regs[11] == 8'h99, "R5 entry after check runs", regs[11], 8'h99);

    // R5 check exceeds poll limit: later write must not run
    mem[1] = mk(2'd1, 14'd12, 8'hFF, 8'h42);
    run_case(2, 2, 0, "D");
    chk(regs[12] != 8'h42, "R5 entry after failed check skipped", regs[12], 8'h42);

    // R10 reserved kind
    mem[0] = mk(2'd1, 14'd13, 8'hFF, 8'h21);
    mem[1] = mk(2'd3, 14'd13, 8'hFF, 8'h77);
    mem[2] = mk(2'd1, 14'd14, 8'hFF, 8'h55);
    run_case(3, 0, 2, "E");
    chk(regs[14] != 8'h55, "R10 entry after reserved skipped", regs[14], 8'h55);

    // R7 full-depth list is accepted
    for (int i = 0; i < 256; i++) mem[i] = mk(2'd0, 14'(i % 60), 8'h00, 8'h00);
    run_case(256, 0, 0, "F");

    // R7 rejected lengths
    bad_start(0, "G0");
    bad_start(6, "G6");
    bad_start(1028, "G1028");

    // R8 start while busy is ignored
    mem[0] = mk(2'd1, 14'd20, 8'hFF, 8'h11);
    mem[1] = mk(2'd2, 14'd63, 8'hFF, 8'h05);
    mem[2] = mk(2'd1, 14'd21, 8'hFF, 8'h22);
    fork
      run_case(3, 10, 2, "H R8");
      begin
        repeat (8) @(negedge clk);
        ctl_wdata = {1'b1, 1'b0, 6'd0, 24'd4};
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
      end
    join

    // R9 stop aborts a running list with no interrupt
    regs[22] = 8'h00;
    mem[0] = mk(2'd2, 14'd63, 8'hFF, 8'hC8);
    mem[1] = mk(2'd1, 14'd22, 8'hFF, 8'h33);
    lat = 1; pctr = 8'd0;
    start(8, 1000, 1'b0);
    repeat (20) @(negedge clk);
    ctl_wdata = 32'h4000_0000; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    t = 0;
    while (busy && t < 10) begin @(negedge clk); t++; end
    chk(!busy, "R9 busy drops after stop", busy, 0);
    t = 0;
    repeat (50) begin
      if (irq_ok || irq_fail || reg_req) t++;
      @(negedge clk);
    end
    chk(t == 0, "R9 no interrupt or access after stop", t, 0);
    chk(regs[22] == 8'h00, "R9 later entry not run", regs[22], 8'h00);

    fin = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule